// File: doc/BRIEF.md
# Expansion ROM Inbound Window

This block sits on the target side of a PCI interface and owns a single address window reserved for a device's expansion ROM. It checks each incoming request against a programmable base/limit pair. A read that lands inside the window is converted into an internal-bus address and served as a delayed transaction. The first attempt is answered with a retry, and the request is parked in a one-entry transaction slot. The block then issues one 64-bit internal-bus fetch, and the returned eight bytes sit in a read-data slot. When the same master retries the same quadword, the held data is returned and the slot is released. The ROM is read-only, so a write that lands in the window is refused with a target abort.

The request and response sides work at transaction level. A request is a one-cycle pulse. Its response is registered and appears one clock later as a two-bit outcome code, with data and a 64-bit acknowledge where they apply. A master that asks for a 64-bit transfer gets all eight bytes. A 32-bit request gets one dword of the fetched quadword. The internal bus is a request pulse with an aligned address, followed at any later time by a single data-return pulse from the memory side.

Top module: `xromWinTop`

## Requirements
- R1: When `cfgEnable` is low, every request gets outcome NOCLAIM (code 0), and no internal-bus request is issued.
- R2: A request hits only when `cfgBase <= reqAddr <= cfgLimit` and the window is enabled. A miss gets NOCLAIM. Each request pulse is followed exactly one clock later by a one-cycle `rspValid` that carries the outcome.
- R3: A write that hits gets outcome ABORT (code 3) and never causes an internal-bus request.
- R4: A read hit while the slot is empty gets RETRY (code 1) and captures the master and quadword address. On the same response cycle it raises `ibReqValid` for exactly one cycle, with `ibReqAddr = ((reqAddr & (cfgLimit - cfgBase)) | cfgXlate)` and bits [2:0] forced to zero. The window must be aligned to its power-of-two size.
- R5: While the internal fetch is outstanding, every read hit gets RETRY and issues no further internal request.
- R6: After the data has returned, a read hit whose master and address bits [ADDR_W-1:3] equal the captured ones gets DATA (code 2) and empties the slot. The next read hit therefore starts a new fetch.
- R7: After the data has returned, a read hit from a different master or quadword gets RETRY and leaves the held request and data unchanged.
- R8: On DATA for a request with `req64` high, `rspAck64` is high and `rspData` is the full fetched quadword. `rspAck64` is low on every other response.
- R9: On DATA for a request with `req64` low, `rspData[31:0]` is the upper fetched dword when `reqAddr[2]` is 1 and the lower dword otherwise. `rspData[63:32]` is zero in that case.
- R10: While reset is active and after it, before any request, `rspValid`, `ibReqValid` and `rspAck64` are low and the slot is empty.
- R11: `ibRspValid` has no effect unless a fetch is outstanding. A stray return while the slot is empty does not make data available to a later read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgEnable | input | 1 | Window decode enable |
| cfgBase | input | ADDR_W | Lowest address of the window |
| cfgLimit | input | ADDR_W | Highest address of the window (inclusive) |
| cfgXlate | input | ADDR_W | Internal-bus base the window maps onto |
| reqValid | input | 1 | One-cycle request strobe |
| reqWrite | input | 1 | Request is a write |
| req64 | input | 1 | Master asks for a 64-bit transfer |
| reqMaster | input | MASTER_W | Requesting master identifier |
| reqAddr | input | ADDR_W | PCI byte address |
| rspValid | output | 1 | Outcome valid, one clock after the request |
| rspCode | output | 2 | 0 NOCLAIM, 1 RETRY, 2 DATA, 3 ABORT |
| rspAck64 | output | 1 | 64-bit transfer acknowledged |
| rspData | output | DATA_W | Read data returned on DATA |
| ibReqValid | output | 1 | Internal-bus read request pulse |
| ibReqAddr | output | ADDR_W | Quadword-aligned internal-bus address |
| ibRspValid | input | 1 | Internal-bus read data return pulse |
| ibRspData | input | DATA_W | Internal-bus read data |

## Verification
The bench builds the block with its defaults: 32-bit addresses, a 64-bit data path and a 2-bit master identifier. It programs a 64 KiB window that maps onto a high internal region. With only four master identifiers and a narrow window, random reads often reuse the pending quadword and master, so matched completions and mismatched retries both occur frequently. The random fetch latency moves the data return before and after later retries, which exercises the fetch-pending and data-held phases.

// File: rtl/xromWinPkg.sv
package xromWinPkg;

  typedef enum logic [1:0] {
    RSP_NOCLAIM = 2'd0,
    RSP_RETRY   = 2'd1,
    RSP_DATA    = 2'd2,
    RSP_ABORT   = 2'd3
  } rspCode_t;

  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_FETCH = 2'd1,
    SLOT_HELD  = 2'd2
  } slotState_t;

  typedef struct packed {
    logic capture;   // record request and translated address
    logic loadData;  // store returned internal-bus data
    logic deliver;   // drive held data onto the response
  } ctrlStrobes_t;

endpackage

// File: rtl/xromWinDatapath.sv
module xromWinDatapath
  import xromWinPkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 64,
  parameter int MASTER_W = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgEnable,
  input  logic [ADDR_W-1:0]   cfgBase,
  input  logic [ADDR_W-1:0]   cfgLimit,
  input  logic [ADDR_W-1:0]   cfgXlate,
  input  logic                req64,
  input  logic [MASTER_W-1:0] reqMaster,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   ibRspData,
  input  ctrlStrobes_t        strobes,
  output logic                winHit,
  output logic                entryMatch,
  output logic [ADDR_W-1:0]   ibReqAddr,
  output logic [DATA_W-1:0]   rspData,
  output logic                rspAck64
);

  localparam int HALF_W   = DATA_W / 2;
  localparam int OFF_BITS = $clog2(DATA_W / 8);
  localparam int QW_W     = ADDR_W - OFF_BITS;

  logic [ADDR_W-1:0]   offMask;
  logic [ADDR_W-1:0]   xlated;
  logic [MASTER_W-1:0] entMaster;
  logic [QW_W-1:0]     entQword;
  logic [DATA_W-1:0]   entData;
  logic [DATA_W-1:0]   selData;

  always_comb begin
    winHit  = cfgEnable && (reqAddr >= cfgBase) && (reqAddr <= cfgLimit);
    offMask = cfgLimit - cfgBase;
    xlated  = (reqAddr & offMask) | cfgXlate;
    xlated[OFF_BITS-1:0] = '0;
    entryMatch = (reqMaster == entMaster) && (reqAddr[ADDR_W-1:OFF_BITS] == entQword);
  end

  always_comb begin
    if (req64) begin
      selData = entData;
    end else if (reqAddr[OFF_BITS-1]) begin
      selData = {{HALF_W{1'b0}}, entData[DATA_W-1:HALF_W]};
    end else begin
      selData = {{HALF_W{1'b0}}, entData[HALF_W-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entMaster <= '0;
      entQword  <= '0;
      entData   <= '0;
      ibReqAddr <= '0;
      rspData   <= '0;
      rspAck64  <= 1'b0;
    end else begin
      if (strobes.capture) begin
        entMaster <= reqMaster;
        entQword  <= reqAddr[ADDR_W-1:OFF_BITS];
        ibReqAddr <= xlated;
      end
      if (strobes.loadData) begin
        entData <= ibRspData;
      end
      rspData  <= strobes.deliver ? selData : '0;
      rspAck64 <= strobes.deliver && req64;
    end
  end

endmodule

// File: rtl/xromWinCtrl.sv
module xromWinCtrl
  import xromWinPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  input  logic         winHit,
  input  logic         entryMatch,
  input  logic         ibRspValid,
  output ctrlStrobes_t strobes,
  output logic         rspValid,
  output logic [1:0]   rspCode,
  output logic         ibReqValid
);

  slotState_t state;
  slotState_t nextState;
  rspCode_t   code;

  always_comb begin
    strobes   = '0;
    code      = RSP_NOCLAIM;
    nextState = state;
    if (ibRspValid && state == SLOT_FETCH) begin
      strobes.loadData = 1'b1;
      nextState        = SLOT_HELD;
    end
    if (reqValid && winHit) begin
      if (reqWrite) begin
        code = RSP_ABORT;
      end else begin
        unique case (state)
          SLOT_EMPTY: begin
            strobes.capture = 1'b1;
            code            = RSP_RETRY;
            nextState       = SLOT_FETCH;
          end
          SLOT_FETCH: begin
            code = RSP_RETRY;
          end
          SLOT_HELD: begin
            if (entryMatch) begin
              strobes.deliver = 1'b1;
              code            = RSP_DATA;
              nextState       = SLOT_EMPTY;
            end else begin
              code = RSP_RETRY;
            end
          end
          default: code = RSP_RETRY;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= SLOT_EMPTY;
      rspValid   <= 1'b0;
      rspCode    <= RSP_NOCLAIM;
      ibReqValid <= 1'b0;
    end else begin
      state      <= nextState;
      rspValid   <= reqValid;
      rspCode    <= reqValid ? code : RSP_NOCLAIM;
      ibReqValid <= strobes.capture;
    end
  end

endmodule

// File: rtl/xromWinTop.sv
module xromWinTop
  import xromWinPkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 64,
  parameter int MASTER_W = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgEnable,
  input  logic [ADDR_W-1:0]   cfgBase,
  input  logic [ADDR_W-1:0]   cfgLimit,
  input  logic [ADDR_W-1:0]   cfgXlate,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic                req64,
  input  logic [MASTER_W-1:0] reqMaster,
  input  logic [ADDR_W-1:0]   reqAddr,
  output logic                rspValid,
  output logic [1:0]          rspCode,
  output logic                rspAck64,
  output logic [DATA_W-1:0]   rspData,
  output logic                ibReqValid,
  output logic [ADDR_W-1:0]   ibReqAddr,
  input  logic                ibRspValid,
  input  logic [DATA_W-1:0]   ibRspData
);

  ctrlStrobes_t strobes;
  logic         winHit;
  logic         entryMatch;

  xromWinCtrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .winHit     (winHit),
    .entryMatch (entryMatch),
    .ibRspValid (ibRspValid),
    .strobes    (strobes),
    .rspValid   (rspValid),
    .rspCode    (rspCode),
    .ibReqValid (ibReqValid)
  );

  xromWinDatapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .MASTER_W (MASTER_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .cfgEnable  (cfgEnable),
    .cfgBase    (cfgBase),
    .cfgLimit   (cfgLimit),
    .cfgXlate   (cfgXlate),
    .req64      (req64),
    .reqMaster  (reqMaster),
    .reqAddr    (reqAddr),
    .ibRspData  (ibRspData),
    .strobes    (strobes),
    .winHit     (winHit),
    .entryMatch (entryMatch),
    .ibReqAddr  (ibReqAddr),
    .rspData    (rspData),
    .rspAck64   (rspAck64)
  );

endmodule

// File: rtl/xromWinChecker.sv
module xromWinChecker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgEnable,
  input logic              reqValid,
  input logic              reqWrite,
  input logic              rspValid,
  input logic [1:0]        rspCode,
  input logic              rspAck64,
  input logic [DATA_W-1:0] rspData,
  input logic              ibReqValid,
  input logic [ADDR_W-1:0] ibReqAddr
);

  localparam int HALF_W = DATA_W / 2;

  AST_DISABLED_NOCLAIM: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !cfgEnable) |=> (rspValid && rspCode == 2'd0)); // R1

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R2

  AST_RSP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid)); // R2

  AST_WRITE_NO_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |=> !ibReqValid); // R3

  AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    ibReqValid |-> (ibReqAddr[2:0] == 3'b000)); // R4

  AST_FETCH_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    ibReqValid |=> !ibReqValid); // R4

  AST_FETCH_WITH_RETRY: assert property (@(posedge clk) disable iff (!rstN)
    ibReqValid |-> (rspValid && rspCode == 2'd1)); // R4

  AST_ACK64_ON_DATA: assert property (@(posedge clk) disable iff (!rstN)
    rspAck64 |-> (rspValid && rspCode == 2'd2)); // R8

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCode == 2'd2 && !rspAck64) |-> (rspData[DATA_W-1:HALF_W] == '0)); // R9

endmodule

bind xromWinTop xromWinChecker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .cfgEnable  (cfgEnable),
  .reqValid   (reqValid),
  .reqWrite   (reqWrite),
  .rspValid   (rspValid),
  .rspCode    (rspCode),
  .rspAck64   (rspAck64),
  .rspData    (rspData),
  .ibReqValid (ibReqValid),
  .ibReqAddr  (ibReqAddr)
);

// File: tb/xromWinTop_tb_top.sv
module xromWinTop_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam int MW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgEnable = 1'b0;
  logic [AW-1:0] cfgBase = 32'h0010_0000;
  logic [AW-1:0] cfgLimit = 32'h0010_FFFF;
  logic [AW-1:0] cfgXlate = 32'h8000_0000;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic          req64 = 1'b0;
  logic [MW-1:0] reqMaster = '0;
  logic [AW-1:0] reqAddr = '0;
  logic          rspValid;
  logic [1:0]    rspCode;
  logic          rspAck64;
  logic [DW-1:0] rspData;
  logic          ibReqValid;
  logic [AW-1:0] ibReqAddr;
  logic          ibRspValid = 1'b0;
  logic [DW-1:0] ibRspData = '0;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  // bench model of the single slot: 0 empty, 1 fetching, 2 held
  int            mState = 0;
  logic [MW-1:0] mMaster = '0;
  logic [AW-4:0] mQword = '0;
  logic [AW-1:0] mFetchAddr = '0;
  logic [DW-1:0] mData = '0;

  xromWinTop dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .cfgEnable  (cfgEnable),
    .cfgBase    (cfgBase),
    .cfgLimit   (cfgLimit),
    .cfgXlate   (cfgXlate),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .req64      (req64),
    .reqMaster  (reqMaster),
    .reqAddr    (reqAddr),
    .rspValid   (rspValid),
    .rspCode    (rspCode),
    .rspAck64   (rspAck64),
    .rspData    (rspData),
    .ibReqValid (ibReqValid),
    .ibReqAddr  (ibReqAddr),
    .ibRspValid (ibRspValid),
    .ibRspData  (ibRspData)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [AW-1:0] expXlate(input logic [AW-1:0] a);
    logic [AW-1:0] r;
    r = (a & (cfgLimit - cfgBase)) | cfgXlate;
    r[2:0] = 3'b000;
    return r;
  endfunction

  function automatic logic [DW-1:0] romPattern(input logic [AW-1:0] a);
    return {a ^ 32'h5A5A_C3C3, a};
  endfunction

  function automatic logic [DW-1:0] expData(input logic [DW-1:0] d, input logic [AW-1:0] a,
                                             input logic wide);
    if (wide) return d;
    return a[2] ? {32'h0, d[63:32]} : {32'h0, d[31:0]};
  endfunction

  function automatic logic expHit(input logic [AW-1:0] a);
    return cfgEnable && (a >= cfgBase) && (a <= cfgLimit);
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReq(input logic wr, input logic [MW-1:0] m, input logic [AW-1:0] a,
                       input logic wide);
    logic          hit;
    logic [1:0]    eCode;
    logic          eIb;
    logic [DW-1:0] eData;
    string         tag;
    hit = expHit(a);
    eIb = 1'b0;
    eData = '0;
    if (!hit) begin
      eCode = 2'd0; tag = cfgEnable ? "R2 miss" : "R1 disabled";
    end else if (wr) begin
      eCode = 2'd3; tag = "R3 write abort";
    end else if (mState == 0) begin
      eCode = 2'd1; eIb = 1'b1; tag = "R4 first read";
    end else if (mState == 1) begin
      eCode = 2'd1; tag = "R5 fetch pending";
    end else if (m == mMaster && a[AW-1:3] == mQword) begin
      eCode = 2'd2; eData = expData(mData, a, wide);
      tag = wide ? "R8 wide completion" : "R9 narrow completion";
    end else begin
      eCode = 2'd1; tag = "R7 mismatch retry";
    end
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqMaster = m; reqAddr = a; req64 = wide;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check({tag, " rspValid"}, {63'h0, rspValid}, 64'h1);
    check({tag, " code"}, {62'h0, rspCode}, {62'h0, eCode});
    check({tag, " ibReqValid"}, {63'h0, ibReqValid}, {63'h0, eIb});
    if (eIb) check("R4 ibReqAddr", {32'h0, ibReqAddr}, {32'h0, expXlate(a)});
    if (eCode == 2'd2) begin
      check({tag, " data R6"}, rspData, eData);
      check("R8 ack64", {63'h0, rspAck64}, {63'h0, wide});
      mState = 0;
    end else begin
      check("R8 ack64 low", {63'h0, rspAck64}, 64'h0);
    end
    if (eIb) begin
      mState = 1; mMaster = m; mQword = a[AW-1:3]; mFetchAddr = expXlate(a);
    end
  endtask

  task automatic serveFetch(input int lat);
    repeat (lat) @(negedge clk);
    ibRspValid = 1'b1;
    ibRspData = romPattern(mFetchAddr);
    @(negedge clk);
    ibRspValid = 1'b0;
    if (mState == 1) begin
      mState = 2; mData = romPattern(mFetchAddr);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 rspValid in reset", {63'h0, rspValid}, 64'h0);
    check("R10 ibReqValid in reset", {63'h0, ibReqValid}, 64'h0);
    check("R10 ack64 in reset", {63'h0, rspAck64}, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 rspValid after reset", {63'h0, rspValid}, 64'h0);

    // R1 disabled window claims nothing
    doReq(1'b0, 2'd0, 32'h0010_0040, 1'b1);
    doReq(1'b1, 2'd0, 32'h0010_0040, 1'b0);
    cfgEnable = 1'b1;
    // R2 boundaries
    doReq(1'b0, 2'd1, 32'h000F_FFFF, 1'b0);
    doReq(1'b0, 2'd1, 32'h0011_0000, 1'b0);
    // R3 write abort
    doReq(1'b1, 2'd1, 32'h0010_0000, 1'b1);
    // R11 stray return while empty, then a read must start a fetch
    serveFetch(0);
    doReq(1'b0, 2'd2, 32'h0010_FFFC, 1'b0);
    doReq(1'b0, 2'd2, 32'h0010_FFFC, 1'b0);  // R5
    serveFetch(2);
    doReq(1'b0, 2'd3, 32'h0010_FFFC, 1'b0);  // R7 other master
    doReq(1'b0, 2'd2, 32'h0010_FFF8, 1'b1);  // R6 same qword, wide
    doReq(1'b0, 2'd2, 32'h0010_FFF8, 1'b0);  // R6 slot freed, new fetch
    serveFetch(1);
    doReq(1'b0, 2'd2, 32'h0010_FFFC, 1'b0);  // R9 upper dword

    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      logic [MW-1:0] m;
      int sel;
      sel = $urandom_range(0, 9);
      m = MW'($urandom_range(0, 3));
      if (mState != 0 && sel < 5) begin
        a = {mQword, 3'b000} | ($urandom_range(0, 1) ? 32'h4 : 32'h0);
        if (sel < 4) m = mMaster;
      end else if (sel < 8) begin
        a = cfgBase + ($urandom & 32'h0000_FFFC);
      end else begin
        a = $urandom & 32'h003F_FFFC;
      end
      if ($urandom_range(0, 29) == 0) cfgEnable = ~cfgEnable;
      doReq($urandom_range(0, 9) == 0, m, a, $urandom_range(0, 1) == 1);
      if (mState == 1 && $urandom_range(0, 9) < 6) serveFetch($urandom_range(0, 3));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule